// File: doc/BRIEF.md
# Video Window Decimation Front End

This block sits on a raw pixel stream that arrives one pixel per clock together with horizontal sync, vertical sync and a field flag. It counts pixels within a line and lines within a field, cuts out a programmable rectangle, and thins that rectangle down by independent horizontal and vertical ratios. Each ratio is set as a drop count on a 64-phase scale. The output is a registered pixel with a valid strobe and a flag that marks the second field of a frame.

Before pixels are dropped, the active pixels of a line pass through a short moving-average prefilter. Its length follows the horizontal drop count: the more pixels are discarded, the longer the average. Sync polarities can be inverted per direction. A single-field mode passes only the field chosen as first. All geometry, ratio and mode settings are captured while vertical sync is active, so software may rewrite them at any time without tearing a field.

Top module: `vid_win_decim`

## Requirements
- R1: Pixel index 0 is the first cycle after active horizontal sync ends. Line index goes up by one on each rising edge of active horizontal sync and is 0 while vertical sync is active, so the first line after vertical sync is line 1. A pixel can be output only if its pixel index lies in [`h_first`, `h_last`] and its line index lies in [`v_first`, `v_last`], bounds inclusive.
- R2: The horizontal keep count is X = 64 - `h_drop`, with X from 1 to 64. In each window line, a 6-bit accumulator cleared at horizontal sync adds X for every window pixel. A pixel is emitted when the sum reaches 64 or more, and 64 is then removed. Over N window pixels this gives floor(N*X/64) outputs.
- R3: The vertical keep count is Y = 64 - `v_drop`. An accumulator cleared at vertical sync adds Y at the start of each window line, and the line is kept when the sum reaches 64 or more. A field of M window lines gives floor(M*Y/64) kept lines.
- R4: The prefilter length is 5 taps when `h_drop` >= 48, 4 taps when it is >= 32, 3 taps when it is >= 16, and 1 tap (the pixel unchanged) below 16. The output is the rounded mean (sum + taps/2) / taps of the current window pixel and the preceding window pixels of the same line. At the first window pixel of a line, that pixel stands in for every earlier tap.
- R5: `hs_inv` = 1 makes horizontal sync active-low and `vs_inv` = 1 makes vertical sync active-low. With 0 each sync is active-high.
- R6: Window bounds, drop counts, `single_field` and `top_sel` are sampled on every cycle while vertical sync is active and are held otherwise. A change made in the middle of a field takes effect only after the next vertical sync.
- R7: The field is first when `field_in`, sampled during vertical sync, equals `top_sel`. With `single_field` = 1, no pixel of a second field is output.
- R8: `pix_second` is 0 for pixels of the first field and 1 for pixels of the second field.
- R9: While `rst_n` is low at a clock edge, `pix_vld` and `pix_out` become 0, and all counters and accumulators are cleared.
- R10: A pixel presented in a cycle appears on `pix_out` with `pix_vld` after one clock edge. `pix_vld` is never high after a cycle in which either sync was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | PIX_W | Input pixel |
| hsync_in | input | 1 | Horizontal sync pin |
| vsync_in | input | 1 | Vertical sync pin |
| field_in | input | 1 | Field flag of the incoming field |
| hs_inv | input | 1 | 1: horizontal sync active-low |
| vs_inv | input | 1 | 1: vertical sync active-low |
| h_first | input | CNT_W | First pixel index of the window |
| h_last | input | CNT_W | Last pixel index of the window |
| v_first | input | CNT_W | First line index of the window |
| v_last | input | CNT_W | Last line index of the window |
| h_drop | input | 6 | Pixels dropped per 64 |
| v_drop | input | 6 | Lines dropped per 64 |
| single_field | input | 1 | 1: output the first field only |
| top_sel | input | 1 | Value of `field_in` that marks the first field |
| pix_out | output | PIX_W | Filtered output pixel |
| pix_vld | output | 1 | Output pixel strobe |
| pix_second | output | 1 | Output pixel belongs to the second field |

## Verification
A wrong pixel counter, a wrong accumulator phase or a wrong filter history shows up on the very next emitted pixel. It appears as a strobe in the wrong cycle or as a value that differs from the rounded mean, so a per-cycle comparison against an independent model exposes it within one line. A vertical accumulator or shadow-register fault only appears at line or field granularity. For that reason the bench also counts emitted pixels per field against hand-derived floor(N*X/64)·floor(M*Y/64) totals. It also rewrites the settings in the middle of a field and checks that nothing changes until the next vertical sync.

// File: rtl/vwd_pkg.sv
// Shared constants and helper functions of the video window decimation front end.
// Assumes the decimation scale is a power of two set by DCM_W.
package vwd_pkg;
    localparam int DCM_W  = 6;
    localparam int PHASES = 1 << DCM_W;

    // Convert a drop count into the keep count (1..PHASES).
    function automatic logic [DCM_W:0] keep_of(input logic [DCM_W-1:0] drop);
        return (DCM_W+1)'(PHASES) - {1'b0, drop};
    endfunction

    // Pick the prefilter length from the horizontal drop count.
    function automatic logic [2:0] taps_of(input logic [DCM_W-1:0] drop);
        if (int'(drop) >= (3 * PHASES) / 4)      return 3'd5;
        else if (int'(drop) >= PHASES / 2)       return 3'd4;
        else if (int'(drop) >= PHASES / 4)       return 3'd3;
        else                                     return 3'd1;
    endfunction
endpackage

// File: rtl/vwd_timing.sv
// Sync polarity handling plus pixel and line counters.
// Assumes one pixel per clock; counters saturate at their maximum.
module vwd_timing #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             hs_inv,
    input  logic             vs_inv,
    output logic             hs_act,
    output logic             vs_act,
    output logic             line_start,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] vline_nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             hs_prev;
    logic [CNT_W-1:0] vcnt;

    assign hs_act     = hsync_in ^ hs_inv;
    assign vs_act     = vsync_in ^ vs_inv;
    assign line_start = hs_act && !hs_prev && !vs_act;
    assign vline_nxt  = (vcnt == CNT_MAX) ? vcnt : vcnt + 1'b1;

    // Remember the previous active horizontal sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_prev <= 1'b0;
        else        hs_prev <= hs_act;
    end

    // Pixel index: zero during sync, counts up afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n || hs_act)   hcnt <= '0;
        else if (hcnt != CNT_MAX) hcnt <= hcnt + 1'b1;
    end

    // Line index: zero during vertical sync, steps on each sync rise.
    always_ff @(posedge clk) begin
        if (!rst_n || vs_act) vcnt <= '0;
        else if (line_start)  vcnt <= vline_nxt;
    end
endmodule

// File: rtl/vwd_phase_acc.sv
// Phase accumulator that decides which of each 64 units to keep.
// Assumes keep is in 1..2**ACC_W; fire is combinational for the current step.
module vwd_phase_acc #(
    parameter int ACC_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [ACC_W:0] keep,
    output logic           fire
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum  = {1'b0, acc} + keep;
    assign fire = sum[ACC_W];

    // Advance the phase; dropping the top bit removes one full period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (step)     acc <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/vwd_box_filter.sv
// Rounded moving average over 1, 3, 4 or 5 window pixels of a line.
// Assumes 'first' marks the first window pixel; it replaces older taps.
module vwd_box_filter #(
    parameter int PIX_W = 8,
    parameter bit EN    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             first,
    input  logic [PIX_W-1:0] pix,
    input  logic [2:0]       taps,
    output logic [PIX_W-1:0] avg
);
    localparam int HIST = 4;
    localparam int SW   = PIX_W + 3;

    generate
        if (EN) begin : g_filt
            logic [PIX_W-1:0] hist [HIST];
            logic [PIX_W-1:0] tap  [HIST];
            logic [SW-1:0]    s3, s4, s5, q;

            // Select history or the replicated current pixel for each tap.
            always_comb begin
                for (int i = 0; i < HIST; i++) tap[i] = first ? pix : hist[i];
            end

            // Partial sums and rounded quotient for the chosen length.
            always_comb begin
                s3 = SW'(pix) + SW'(tap[0]) + SW'(tap[1]);
                s4 = s3 + SW'(tap[2]);
                s5 = s4 + SW'(tap[3]);
                case (taps)
                    3'd5:    q = (s5 + SW'(2)) / SW'(5);
                    3'd4:    q = (s4 + SW'(2)) >> 2;
                    3'd3:    q = (s3 + SW'(1)) / SW'(3);
                    default: q = SW'(pix);
                endcase
                avg = q[PIX_W-1:0];
            end

            // Shift window pixels into the history.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < HIST; i++) hist[i] <= '0;
                end else if (en) begin
                    hist[0] <= pix;
                    for (int i = 1; i < HIST; i++) hist[i] <= tap[i-1];
                end
            end
        end else begin : g_bypass
            assign avg = pix;
        end
    endgenerate
endmodule

// File: rtl/vid_win_decim.sv
// Top of the video window decimation front end: windowing, shadowed settings,
// 64-phase horizontal and vertical decimation, prefilter and output register.
// Assumes one pixel per clock and h_first <= h_last for a non-empty window.
module vid_win_decim
    import vwd_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int CNT_W     = 10,
    parameter bit FILTER_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             field_in,
    input  logic             hs_inv,
    input  logic             vs_inv,
    input  logic [CNT_W-1:0] h_first,
    input  logic [CNT_W-1:0] h_last,
    input  logic [CNT_W-1:0] v_first,
    input  logic [CNT_W-1:0] v_last,
    input  logic [DCM_W-1:0] h_drop,
    input  logic [DCM_W-1:0] v_drop,
    input  logic             single_field,
    input  logic             top_sel,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld,
    output logic             pix_second
);
    logic             hs_act, vs_act, line_start;
    logic [CNT_W-1:0] hcnt, vline_nxt;

    logic [CNT_W-1:0] sh_hf, sh_hl, sh_vf, sh_vl;
    logic [DCM_W-1:0] sh_hd, sh_vd;
    logic             sh_single, sh_top, fld_q;

    logic             in_h, in_v_nxt, first_field, line_ok;
    logic             v_fire, h_fire;
    logic [PIX_W-1:0] filt;

    vwd_timing #(.CNT_W(CNT_W)) u_timing (
        .clk(clk), .rst_n(rst_n),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hs_inv(hs_inv), .vs_inv(vs_inv),
        .hs_act(hs_act), .vs_act(vs_act), .line_start(line_start),
        .hcnt(hcnt), .vline_nxt(vline_nxt)
    );

    // Capture settings and the field flag while vertical sync is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hf <= '0; sh_hl <= '0; sh_vf <= '0; sh_vl <= '0;
            sh_hd <= '0; sh_vd <= '0;
            sh_single <= 1'b0; sh_top <= 1'b0; fld_q <= 1'b0;
        end else if (vs_act) begin
            sh_hf <= h_first; sh_hl <= h_last;
            sh_vf <= v_first; sh_vl <= v_last;
            sh_hd <= h_drop;  sh_vd <= v_drop;
            sh_single <= single_field; sh_top <= top_sel; fld_q <= field_in;
        end
    end

    assign in_h        = !hs_act && !vs_act && (hcnt >= sh_hf) && (hcnt <= sh_hl);
    assign in_v_nxt    = (vline_nxt >= sh_vf) && (vline_nxt <= sh_vl);
    assign first_field = (fld_q == sh_top);

    vwd_phase_acc #(.ACC_W(DCM_W)) u_vacc (
        .clk(clk), .rst_n(rst_n), .clr(vs_act),
        .step(line_start && in_v_nxt), .keep(keep_of(sh_vd)), .fire(v_fire)
    );

    // Decide at each line start whether the coming line is output.
    always_ff @(posedge clk) begin
        if (!rst_n || vs_act) line_ok <= 1'b0;
        else if (line_start)  line_ok <= in_v_nxt && v_fire && (!sh_single || first_field);
    end

    vwd_phase_acc #(.ACC_W(DCM_W)) u_hacc (
        .clk(clk), .rst_n(rst_n), .clr(hs_act || vs_act),
        .step(in_h && line_ok), .keep(keep_of(sh_hd)), .fire(h_fire)
    );

    vwd_box_filter #(.PIX_W(PIX_W), .EN(FILTER_EN)) u_filt (
        .clk(clk), .rst_n(rst_n), .en(in_h), .first(in_h && (hcnt == sh_hf)),
        .pix(pix_in), .taps(taps_of(sh_hd)), .avg(filt)
    );

    // Register the emitted pixel, its strobe and its field marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_vld <= 1'b0; pix_out <= '0; pix_second <= 1'b0;
        end else begin
            pix_vld <= in_h && line_ok && h_fire;
            if (in_h && line_ok && h_fire) begin
                pix_out    <= filt;
                pix_second <= !first_field;
            end
        end
    end
endmodule

// File: rtl/vwd_chk.sv
// Property checker for the video window decimation front end, bound to the top.
// Assumes access to the captured horizontal drop count and single-field setting.
module vwd_chk #(
    parameter int PIX_W = 8,
    parameter int DCM_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_in,
    input logic             vsync_in,
    input logic             hs_inv,
    input logic             vs_inv,
    input logic [PIX_W-1:0] pix_in,
    input logic [PIX_W-1:0] pix_out,
    input logic             pix_vld,
    input logic             pix_second,
    input logic [DCM_W-1:0] sh_hd,
    input logic             sh_single
);
    // R10
    sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> $past(((hsync_in ^ hs_inv) == 1'b0) && ((vsync_in ^ vs_inv) == 1'b0)));

    // R2
    half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && $past(pix_vld)) |-> (int'(sh_hd) < 32));

    // R4
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && int'(sh_hd) < 16) |-> (pix_out == $past(pix_in)));

    // R7
    single_fld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && sh_single) |-> !pix_second);

    // R9
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pix_vld && pix_out == '0));
endmodule

bind vid_win_decim vwd_chk #(.PIX_W(PIX_W), .DCM_W(vwd_pkg::DCM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hs_inv(hs_inv), .vs_inv(vs_inv), .pix_in(pix_in), .pix_out(pix_out),
    .pix_vld(pix_vld), .pix_second(pix_second), .sh_hd(sh_hd), .sh_single(sh_single)
);

// File: tb/vid_win_decim_tb.sv
`timescale 1ns/1ps
// Bench: table-driven frames compared per cycle against a behavioural model,
// plus directed reset, settings-capture and boundary tests.
module vid_win_decim_tb;
    localparam int NP = 40;
    localparam int NL = 12;
    localparam int NV = 9;
    localparam int NF = 12;

    // hf, hl, vf, vl, hd, vd, single, top, hinv, vinv, fld, expected count
    localparam int VEC [NV][NF] = '{
        '{4, 35, 2, 9,  0,  0, 0, 0, 0, 0, 0, 256},
        '{0, 39, 1, 12, 32, 32, 0, 0, 0, 0, 0, 120},
        '{0, 39, 1, 12, 48, 16, 0, 0, 0, 0, 0,  90},
        '{3, 30, 1, 12, 16, 56, 0, 0, 0, 0, 0,  21},
        '{0, 39, 1, 12, 15,  8, 0, 0, 1, 1, 0, 300},
        '{0, 39, 1, 12,  0,  0, 1, 1, 0, 0, 1, 480},
        '{0, 39, 1, 12,  0,  0, 1, 1, 0, 0, 0,   0},
        '{0, 39, 1, 12,  0,  0, 0, 1, 0, 0, 0, 480},
        '{0, 39, 1, 12, 62,  0, 0, 0, 0, 0, 0,  12}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [7:0] pix_in;
    logic hsync_in, vsync_in, field_in, hs_inv, vs_inv;
    logic [9:0] h_first, h_last, v_first, v_last;
    logic [5:0] h_drop, v_drop;
    logic single_field, top_sel;
    logic [7:0] pix_out;
    logic pix_vld, pix_second;

    int n_vec = 0;
    int n_bad = 0;
    int n_out = 0;

    // model state
    int m_hf, m_hl, m_vf, m_vl, m_hd, m_vd, m_single, m_top, m_fld;
    int m_hcnt, m_vcnt, m_hacc, m_vacc, m_lok, m_hprev;
    int m_hist [4];
    int e_vld, e_pix, e_sec;

    always #2 clk = ~clk;

    vid_win_decim u_dut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .field_in(field_in), .hs_inv(hs_inv), .vs_inv(vs_inv),
        .h_first(h_first), .h_last(h_last), .v_first(v_first), .v_last(v_last),
        .h_drop(h_drop), .v_drop(v_drop), .single_field(single_field),
        .top_sel(top_sel), .pix_out(pix_out), .pix_vld(pix_vld), .pix_second(pix_second)
    );

    function automatic string tag_of(input int i);
        case (i)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R3";
            4: return "R5";
            5: return "R7";
            6: return "R7";
            7: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hf = 0; m_hl = 0; m_vf = 0; m_vl = 0; m_hd = 0; m_vd = 0;
        m_single = 0; m_top = 0; m_fld = 0;
        m_hcnt = 0; m_vcnt = 0; m_hacc = 0; m_vacc = 0; m_lok = 0; m_hprev = 0;
        for (int i = 0; i < 4; i++) m_hist[i] = 0;
    endtask

    // One clock of stimulus in active-sync terms, model update and comparison.
    task automatic step(input int hsa, input int vsa, input int fld, input int px, input string tag);
        int n, sum, s, first;
        int w [5];
        @(negedge clk);
        hsync_in = 1'(hsa) ^ hs_inv;
        vsync_in = 1'(vsa) ^ vs_inv;
        field_in = 1'(fld);
        pix_in   = 8'(px);
        e_vld = 0;
        if (hsa == 0 && vsa == 0 && m_hcnt >= m_hf && m_hcnt <= m_hl) begin
            first = (m_hcnt == m_hf);
            n = (m_hd >= 48) ? 5 : (m_hd >= 32) ? 4 : (m_hd >= 16) ? 3 : 1;
            w[0] = px & 255;
            for (int i = 1; i < 5; i++) w[i] = first ? (px & 255) : m_hist[i-1];
            sum = 0;
            for (int i = 0; i < n; i++) sum += w[i];
            for (int i = 3; i > 0; i--) m_hist[i] = w[i];
            m_hist[0] = px & 255;
            if (m_lok != 0) begin
                s = m_hacc + 64 - m_hd;
                if (s >= 64) begin
                    e_vld = 1;
                    e_pix = (sum + n / 2) / n;
                    e_sec = (m_fld == m_top) ? 0 : 1;
                    s -= 64;
                end
                m_hacc = s;
            end
        end
        if (vsa != 0) begin
            m_hf = int'(h_first); m_hl = int'(h_last);
            m_vf = int'(v_first); m_vl = int'(v_last);
            m_hd = int'(h_drop);  m_vd = int'(v_drop);
            m_single = int'(single_field); m_top = int'(top_sel); m_fld = fld;
            m_vcnt = 0; m_vacc = 0; m_lok = 0;
        end else if (hsa != 0 && m_hprev == 0) begin
            if (m_vcnt < 1023) m_vcnt++;
            m_lok = 0;
            if (m_vcnt >= m_vf && m_vcnt <= m_vl) begin
                s = m_vacc + 64 - m_vd;
                if (s >= 64) begin
                    s -= 64;
                    m_lok = (m_single == 0 || m_fld == m_top) ? 1 : 0;
                end
                m_vacc = s;
            end
        end
        if (hsa != 0 || vsa != 0) m_hacc = 0;
        if (hsa != 0) m_hcnt = 0;
        else if (m_hcnt < 1023) m_hcnt++;
        m_hprev = hsa;
        @(posedge clk);
        #1;
        if (pix_vld) n_out++;
        check(tag, int'(pix_vld), e_vld);
        if (e_vld != 0) begin
            check(tag, int'(pix_out), e_pix);
            check(tag, int'(pix_second), e_sec);
        end
    endtask

    // One field: vertical sync, idle, then NL lines of NP pixels.
    task automatic run_frame(input int fld, input int frm, input int mid, input string tag);
        for (int i = 0; i < 2; i++) step(0, 1, fld, 0, tag);
        for (int i = 0; i < 3; i++) step(0, 0, fld, 0, tag);
        for (int l = 1; l <= NL; l++) begin
            if (mid != 0 && l == 6) h_drop = 6'd32;
            for (int i = 0; i < 2; i++) step(1, 0, fld, 0, tag);
            for (int p = 0; p < NP; p++) step(0, 0, fld, (l * 29 + p * 11 + frm * 7) & 255, tag);
        end
    endtask

    task automatic set_cfg(input int hf, input int hl, input int vf, input int vl,
                           input int hd, input int vd);
        h_first = 10'(hf); h_last = 10'(hl); v_first = 10'(vf); v_last = 10'(vl);
        h_drop = 6'(hd); v_drop = 6'(vd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pix_in = '0; hsync_in = 1'b0; vsync_in = 1'b0; field_in = 1'b0;
        hs_inv = 1'b0; vs_inv = 1'b0; single_field = 1'b0; top_sel = 1'b0;
        set_cfg(0, 0, 0, 0, 0, 0);
        do_reset();
        // R9: outputs cleared by reset
        check("R9", int'(pix_vld), 0);
        check("R9", int'(pix_out), 0);

        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            single_field = 1'(VEC[v][6]); top_sel = 1'(VEC[v][7]);
            hs_inv = 1'(VEC[v][8]); vs_inv = 1'(VEC[v][9]);
            run_frame(VEC[v][10], v, 0, tag_of(v));
            n_out = 0;
            run_frame(VEC[v][10], v + 1, 0, tag_of(v));
            check(tag_of(v), n_out, VEC[v][11]);
        end

        // R6: mid-field drop change ignored until the next vertical sync
        hs_inv = 1'b0; vs_inv = 1'b0; single_field = 1'b0; top_sel = 1'b0;
        set_cfg(4, 35, 2, 9, 0, 0);
        run_frame(0, 20, 0, "R6");
        n_out = 0;
        run_frame(0, 21, 1, "R6");
        check("R6", n_out, 256);
        n_out = 0;
        run_frame(0, 22, 0, "R6");
        check("R6", n_out, 128);

        // R1: single pixel window
        set_cfg(20, 20, 5, 5, 0, 0);
        run_frame(0, 23, 0, "R1");
        n_out = 0;
        run_frame(0, 24, 0, "R1");
        check("R1", n_out, 1);

        // R9: reset in the middle of a field clears the output
        set_cfg(0, 39, 1, 12, 0, 0);
        run_frame(0, 25, 0, "R9");
        for (int i = 0; i < 2; i++) step(1, 0, 0, 0, "R9");
        for (int p = 0; p < 10; p++) step(0, 0, 0, p * 5, "R9");
        do_reset();
        check("R9", int'(pix_vld), 0);
        check("R9", int'(pix_out), 0);
        // R10: after reset, pixels flow again one edge after presentation
        n_out = 0;
        run_frame(0, 26, 0, "R10");
        check("R10", n_out, 480);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule